// File: doc/BRIEF.md
# MSI Cache Line Coherence Controller

This block is the cache-side coherence engine for a single cache line in a directory-based MSI scheme. It accepts three streams of events. The first is processor operations: load, store and eviction. The second is forwarded messages from the directory: a forwarded read, a forwarded write, an invalidate, and a put acknowledgement. The third is response messages: data, which carries the number of invalidation acks to expect, and invalidation acks. It issues coherence requests to the directory and sends data or invalidation acks back to other caches.

The controller does not block forwarded messages while a fill is outstanding or while it is still collecting invalidation acks. It takes such a message at once and records it in a compound transient state. The deferred part of the work, which is to hand data onward and to drop or downgrade the line, is done when the transaction completes. Acks that arrive before the data are counted in a signed counter, so data carrying a non-zero ack count can still finish the transaction immediately.

The controller takes at most one event per cycle. A response has priority over a forwarded message, and a forwarded message has priority over a processor operation. Every action it emits appears on registered outputs one cycle after the event is taken.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset, and after any later reset, the line is invalid: all outputs are low, `fwd_ready` is high, and a store issues a write request. An eviction in the invalid state is accepted without stalling and produces no output.
- R2: In the invalid state, a load issues a read request (`req_kind`=0) and a store issues a write request (`req_kind`=1).
- R3: While a read fill is pending, an invalidate (`fwd_kind`=2) is answered with an ack on `inv_ack_out` in the next cycle. The later data then leaves the line invalid. Without an invalidate, the data (`rsp_kind`=0) leaves the line shared.
- R4: When data arrives during a write fill, the line becomes modified if its ack count (`rsp_acks`) plus the acks already received (`rsp_kind`=1) nets to zero. Otherwise the controller waits for the remaining acks.
- R5: The invalidation ack that brings the outstanding count to zero completes the write. With no deferred request, the line ends modified, so an eviction then issues a write-back (`req_kind`=3 together with `data_to_dir`).
- R6: A forwarded read (`fwd_kind`=0) taken while acks are being gathered produces, on the last ack, data to both requester and directory, and the line ends shared. A forwarded write (`fwd_kind`=1) produces data to the requester only, and the line ends invalid.
- R7: An invalidate that follows a deferred forwarded read is acked immediately. On the last ack, data goes to both requester and directory, and the line ends invalid.
- R8: In the shared state, a load hits with no output, a store issues a write request, an eviction issues a clean put (`req_kind`=2), and an invalidate is acked and drops the line.
- R9: During an upgrade from shared to modified, loads hit. An invalidate is acked, and the upgrade then continues as a write fill from invalid.
- R10: In the modified state, a forwarded read sends data to requester and directory and the line ends shared. A forwarded write sends data to the requester only and the line ends invalid.
- R11: While a put is outstanding, a forwarded read sends data to both requester and directory, a forwarded write sends data to the requester, an invalidate is acked, and a put acknowledgement (`fwd_kind`=3) returns the line to invalid.
- R12: In every transient state, loads, stores and evictions raise `cpu_stall`, except loads during an upgrade from shared, which hit. A processor operation also stalls in any cycle in which a message is valid.
- R13: A response is always taken. A forwarded message is taken only when no response is valid. A forwarded read or write that arrives during a write fill is held with `fwd_ready` low until the data has been taken, and is then served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor operation present |
| cpu_op | input | 2 | 0 load, 1 store, 2 eviction |
| cpu_stall | output | 1 | Operation not taken this cycle; hold it |
| fwd_valid | input | 1 | Forwarded message present |
| fwd_kind | input | 2 | 0 forwarded read, 1 forwarded write, 2 invalidate, 3 put acknowledgement |
| fwd_ready | output | 1 | Forwarded message taken when valid |
| rsp_valid | input | 1 | Response message present |
| rsp_kind | input | 1 | 0 data, 1 invalidation ack |
| rsp_acks | input | $clog2(NCACHES) | Ack count carried by data |
| req_valid | output | 1 | Request to directory this cycle |
| req_kind | output | 2 | 0 read, 1 write, 2 clean put, 3 write-back put |
| data_to_req | output | 1 | Send line data to the requesting cache |
| data_to_dir | output | 1 | Send line data to the directory |
| inv_ack_out | output | 1 | Send invalidation ack to the requester |

## Verification
The stimulus is one long event trace. It visits every compound transient state, entering each by its own path: acks arriving before the data, data with a zero ack count and with a non-zero ack count, and forwarded reads versus forwarded writes during the gather. Each of these paths changes which of the data and ack outputs appear and when they appear. The final stable state is never read directly. It is shown by the request that the next processor operation produces, which tells an invalid line apart from a shared or a modified one. Directed tests then hold a forwarded message against a pending fill, present a processor operation together with a message, and apply reset in the middle of a transaction.

// File: rtl/mcl_pkg.sv
package mcl_pkg;

    typedef enum logic [4:0] {
        ST_INV, ST_SHR, ST_MOD,
        ST_I2S_D, ST_I2S_D_X,
        ST_I2M_AD, ST_I2M_A, ST_I2M_A_S, ST_I2M_A_SX, ST_I2M_A_X,
        ST_S2M_AD, ST_S2M_A, ST_S2M_A_S, ST_S2M_A_SX, ST_S2M_A_X,
        ST_M2I_A, ST_S2I_A, ST_X2I_A
    } line_st_e;

    typedef enum logic [1:0] {OP_LOAD, OP_STORE, OP_EVICT, OP_NONE} cpu_op_e;
    typedef enum logic [1:0] {FW_GETS, FW_GETM, FW_INV, FW_PUTACK} fwd_e;
    typedef enum logic       {RS_DATA, RS_IACK} rsp_e;
    typedef enum logic [1:0] {RQ_GETS, RQ_GETM, RQ_PUTS, RQ_PUTM} req_e;

    typedef struct packed {
        logic req_v;
        req_e req_kind;
        logic dat_req;
        logic dat_dir;
        logic iack;
    } act_t;

    function automatic logic is_stable(line_st_e s);
        return s inside {ST_INV, ST_SHR, ST_MOD};
    endfunction

    function automatic logic is_fill(line_st_e s);
        return s inside {ST_I2M_AD, ST_S2M_AD};
    endfunction

    function automatic logic is_gather(line_st_e s);
        return s inside {ST_I2M_A, ST_I2M_A_S, ST_I2M_A_SX, ST_I2M_A_X,
                         ST_S2M_A, ST_S2M_A_S, ST_S2M_A_SX, ST_S2M_A_X};
    endfunction

    function automatic logic cpu_ok(line_st_e s, cpu_op_e op);
        return is_stable(s) || ((s inside {ST_S2M_AD, ST_S2M_A}) && op == OP_LOAD);
    endfunction

    function automatic logic fwd_wait(line_st_e s, fwd_e k);
        return is_fill(s) && (k inside {FW_GETS, FW_GETM});
    endfunction

    function automatic logic fwd_legal(line_st_e s, fwd_e k);
        case (k)
            FW_GETS, FW_GETM: return s inside {ST_I2M_A, ST_S2M_A, ST_MOD, ST_M2I_A};
            FW_INV:    return s inside {ST_SHR, ST_I2S_D, ST_S2M_AD, ST_I2M_A_S,
                                        ST_S2M_A_S, ST_S2I_A};
            default:   return s inside {ST_M2I_A, ST_S2I_A, ST_X2I_A};
        endcase
    endfunction

    function automatic logic rsp_legal(line_st_e s, rsp_e k);
        if (k == RS_DATA) return s inside {ST_I2S_D, ST_I2S_D_X, ST_I2M_AD, ST_S2M_AD};
        return is_fill(s) || is_gather(s);
    endfunction

endpackage

// File: rtl/mcl_arbiter.sv
module mcl_arbiter
    import mcl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  line_st_e st,
    input  logic     cpu_valid,
    input  cpu_op_e  cpu_op,
    input  logic     fwd_valid,
    input  fwd_e     fwd_kind,
    input  logic     rsp_valid,
    output logic     take_cpu,
    output logic     take_fwd,
    output logic     take_rsp,
    output logic     fwd_ready,
    output logic     cpu_stall
);
    always_comb begin
        take_rsp  = rsp_valid;
        fwd_ready = !rsp_valid && !fwd_wait(st, fwd_kind);
        take_fwd  = fwd_valid && fwd_ready;
        take_cpu  = cpu_valid && !rsp_valid && !fwd_valid && cpu_ok(st, cpu_op);
        cpu_stall = cpu_valid && !take_cpu;
    end

    // R13: at most one event consumed per cycle
    a_r13_single_take: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take_rsp, take_fwd, take_cpu}));

    // R12: stores never proceed in a transient state
    a_r12_store_stalls: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_op == OP_STORE && !is_stable(st)) |-> cpu_stall);
endmodule

// File: rtl/mcl_ack_counter.sv
module mcl_ack_counter
    import mcl_pkg::*;
#(
    parameter int NCACHES = 8,
    localparam int AW = $clog2(NCACHES),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dec,
    input  logic          load,
    input  logic [AW-1:0] acks,
    output logic          dec_zero,
    output logic          sum_zero,
    output logic          idle
);
    logic signed [CW-1:0] cnt_q;
    logic signed [CW-1:0] sum;

    assign sum      = cnt_q + $signed({1'b0, acks});
    assign dec_zero = (cnt_q == CW'(1));
    assign sum_zero = (sum == '0);
    assign idle     = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= sum;
        else if (dec)  cnt_q <= cnt_q - CW'(1);
    end

    // R4: outstanding count stays within the number of other caches
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= $signed(CW'(NCACHES - 1))) && (cnt_q >= -$signed(CW'(NCACHES - 1))));
endmodule

// File: rtl/mcl_next_state.sv
module mcl_next_state
    import mcl_pkg::*;
(
    input  line_st_e st,
    input  logic     take_cpu,
    input  cpu_op_e  cpu_op,
    input  logic     take_fwd,
    input  fwd_e     fwd_kind,
    input  logic     take_rsp,
    input  rsp_e     rsp_kind,
    input  logic     dec_zero,
    input  logic     sum_zero,
    output line_st_e nxt,
    output act_t     act
);
    logic data_in, last_ack;
    assign data_in  = take_rsp && rsp_kind == RS_DATA;
    assign last_ack = take_rsp && rsp_kind == RS_IACK && dec_zero;

    always_comb begin
        nxt = st;
        act = '0;
        if (take_rsp) begin
            case (st)
                ST_I2S_D:   if (data_in) nxt = ST_SHR;
                ST_I2S_D_X: if (data_in) nxt = ST_INV;
                ST_I2M_AD:  if (data_in) nxt = sum_zero ? ST_MOD : ST_I2M_A;
                ST_S2M_AD:  if (data_in) nxt = sum_zero ? ST_MOD : ST_S2M_A;
                ST_I2M_A, ST_S2M_A: if (last_ack) nxt = ST_MOD;
                ST_I2M_A_S, ST_S2M_A_S: if (last_ack) begin
                    nxt = ST_SHR; act.dat_req = 1'b1; act.dat_dir = 1'b1;
                end
                ST_I2M_A_SX, ST_S2M_A_SX: if (last_ack) begin
                    nxt = ST_INV; act.dat_req = 1'b1; act.dat_dir = 1'b1;
                end
                ST_I2M_A_X, ST_S2M_A_X: if (last_ack) begin
                    nxt = ST_INV; act.dat_req = 1'b1;
                end
                default: ;
            endcase
        end else if (take_fwd) begin
            case (st)
                ST_I2S_D:  if (fwd_kind == FW_INV) begin nxt = ST_I2S_D_X; act.iack = 1'b1; end
                ST_SHR:    if (fwd_kind == FW_INV) begin nxt = ST_INV;     act.iack = 1'b1; end
                ST_S2M_AD: if (fwd_kind == FW_INV) begin nxt = ST_I2M_AD;  act.iack = 1'b1; end
                ST_I2M_A_S: if (fwd_kind == FW_INV) begin nxt = ST_I2M_A_SX; act.iack = 1'b1; end
                ST_S2M_A_S: if (fwd_kind == FW_INV) begin nxt = ST_S2M_A_SX; act.iack = 1'b1; end
                ST_I2M_A: if (fwd_kind == FW_GETS) nxt = ST_I2M_A_S;
                          else if (fwd_kind == FW_GETM) nxt = ST_I2M_A_X;
                ST_S2M_A: if (fwd_kind == FW_GETS) nxt = ST_S2M_A_S;
                          else if (fwd_kind == FW_GETM) nxt = ST_S2M_A_X;
                ST_MOD: if (fwd_kind == FW_GETS) begin
                            nxt = ST_SHR; act.dat_req = 1'b1; act.dat_dir = 1'b1;
                        end else if (fwd_kind == FW_GETM) begin
                            nxt = ST_INV; act.dat_req = 1'b1;
                        end
                ST_M2I_A: if (fwd_kind == FW_GETS) begin
                              nxt = ST_S2I_A; act.dat_req = 1'b1; act.dat_dir = 1'b1;
                          end else if (fwd_kind == FW_GETM) begin
                              nxt = ST_X2I_A; act.dat_req = 1'b1;
                          end else if (fwd_kind == FW_PUTACK) nxt = ST_INV;
                ST_S2I_A: if (fwd_kind == FW_INV) begin nxt = ST_X2I_A; act.iack = 1'b1; end
                          else if (fwd_kind == FW_PUTACK) nxt = ST_INV;
                ST_X2I_A: if (fwd_kind == FW_PUTACK) nxt = ST_INV;
                default: ;
            endcase
        end else if (take_cpu) begin
            case (st)
                ST_INV: if (cpu_op == OP_LOAD) begin
                            nxt = ST_I2S_D; act.req_v = 1'b1; act.req_kind = RQ_GETS;
                        end else if (cpu_op == OP_STORE) begin
                            nxt = ST_I2M_AD; act.req_v = 1'b1; act.req_kind = RQ_GETM;
                        end
                ST_SHR: if (cpu_op == OP_STORE) begin
                            nxt = ST_S2M_AD; act.req_v = 1'b1; act.req_kind = RQ_GETM;
                        end else if (cpu_op == OP_EVICT) begin
                            nxt = ST_S2I_A; act.req_v = 1'b1; act.req_kind = RQ_PUTS;
                        end
                ST_MOD: if (cpu_op == OP_EVICT) begin
                            nxt = ST_M2I_A; act.req_v = 1'b1; act.req_kind = RQ_PUTM;
                            act.dat_dir = 1'b1;
                        end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import mcl_pkg::*;
#(
    parameter int NCACHES = 8,
    localparam int AW = $clog2(NCACHES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_valid,
    input  logic [1:0]    cpu_op,
    output logic          cpu_stall,
    input  logic          fwd_valid,
    input  logic [1:0]    fwd_kind,
    output logic          fwd_ready,
    input  logic          rsp_valid,
    input  logic          rsp_kind,
    input  logic [AW-1:0] rsp_acks,
    output logic          req_valid,
    output logic [1:0]    req_kind,
    output logic          data_to_req,
    output logic          data_to_dir,
    output logic          inv_ack_out
);
    line_st_e st_q, st_d;
    act_t     act_d, act_q;
    cpu_op_e  op;
    fwd_e     fk;
    rsp_e     rk;
    logic     take_cpu, take_fwd, take_rsp;
    logic     dec_zero, sum_zero, cnt_idle;

    assign op = cpu_op_e'(cpu_op);
    assign fk = fwd_e'(fwd_kind);
    assign rk = rsp_e'(rsp_kind);

    mcl_arbiter u_arb (
        .clk(clk), .rst(rst), .st(st_q),
        .cpu_valid(cpu_valid), .cpu_op(op),
        .fwd_valid(fwd_valid), .fwd_kind(fk), .rsp_valid(rsp_valid),
        .take_cpu(take_cpu), .take_fwd(take_fwd), .take_rsp(take_rsp),
        .fwd_ready(fwd_ready), .cpu_stall(cpu_stall)
    );

    mcl_ack_counter #(.NCACHES(NCACHES)) u_cnt (
        .clk(clk), .rst(rst),
        .dec (take_rsp && rk == RS_IACK && (is_fill(st_q) || is_gather(st_q))),
        .load(take_rsp && rk == RS_DATA && is_fill(st_q)),
        .acks(rsp_acks),
        .dec_zero(dec_zero), .sum_zero(sum_zero), .idle(cnt_idle)
    );

    mcl_next_state u_ns (
        .st(st_q), .take_cpu(take_cpu), .cpu_op(op),
        .take_fwd(take_fwd), .fwd_kind(fk),
        .take_rsp(take_rsp), .rsp_kind(rk),
        .dec_zero(dec_zero), .sum_zero(sum_zero),
        .nxt(st_d), .act(act_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_INV;
            act_q <= '0;
        end else begin
            st_q  <= st_d;
            act_q <= act_d;
        end
    end

    assign req_valid   = act_q.req_v;
    assign req_kind    = act_q.req_kind;
    assign data_to_req = act_q.dat_req;
    assign data_to_dir = act_q.dat_dir;
    assign inv_ack_out = act_q.iack;

    // R13: only messages defined for the current state are accepted
    a_r13_fwd_legal: assert property (@(posedge clk) disable iff (rst)
        take_fwd |-> fwd_legal(st_q, fk));
    a_r13_rsp_legal: assert property (@(posedge clk) disable iff (rst)
        take_rsp |-> rsp_legal(st_q, rk));

    // R1: no acks are outstanding in a stable state
    a_r1_idle_count: assert property (@(posedge clk) disable iff (rst)
        is_stable(st_q) |-> cnt_idle);

    // R5: the last ack of a gather always lands in a stable state
    a_r5_last_ack_exits: assert property (@(posedge clk) disable iff (rst)
        (is_gather(st_q) && take_rsp && rk == RS_IACK && dec_zero) |=> is_stable(st_q));

    // R12: a request to the directory never coincides with an outgoing inv ack
    a_r12_req_excl: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && inv_ack_out));
endmodule

// File: tb/msi_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_line_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_valid, fwd_valid, rsp_valid, rsp_kind;
    logic [1:0] cpu_op, fwd_kind;
    logic [2:0] rsp_acks;
    logic       cpu_stall, fwd_ready, req_valid, data_to_req, data_to_dir, inv_ack_out;
    logic [1:0] req_kind;

    always #4 clk = ~clk;

    msi_line_ctrl #(.NCACHES(8)) dut_i (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_stall(cpu_stall),
        .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_ready(fwd_ready),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_acks(rsp_acks),
        .req_valid(req_valid), .req_kind(req_kind),
        .data_to_req(data_to_req), .data_to_dir(data_to_dir), .inv_ack_out(inv_ack_out)
    );

    // event sources
    localparam logic [1:0] S_CPU = 2'd1, S_FWD = 2'd2, S_RSP = 2'd3;
    localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_EV = 2'd2;
    localparam logic [1:0] K_FRD = 2'd0, K_FWR = 2'd1, K_INV = 2'd2, K_PAK = 2'd3;
    localparam logic [1:0] K_DAT = 2'd0, K_ACK = 2'd1;
    // expected {req_valid, req_kind, data_to_req, data_to_dir, inv_ack_out}
    localparam logic [5:0] E_NONE = 6'b000000, E_GETS = 6'b100000, E_GETM = 6'b101000,
                           E_PUTS = 6'b110000, E_PUTM = 6'b111010, E_IACK = 6'b000001,
                           E_BOTH = 6'b000110, E_REQ  = 6'b000100;

    // {source, kind, acks, expected, requirement}
    localparam int NV = 64;
    localparam logic [17:0] VEC [NV] = '{
        {S_CPU, K_LD,  4'd0, E_GETS, 4'd2},   // R2
        {S_RSP, K_DAT, 4'd0, E_NONE, 4'd3},   // R3 fill -> shared
        {S_CPU, K_LD,  4'd0, E_NONE, 4'd8},   // R8 load hit
        {S_FWD, K_INV, 4'd0, E_IACK, 4'd8},   // R8 inv drops
        {S_CPU, K_LD,  4'd0, E_GETS, 4'd3},
        {S_FWD, K_INV, 4'd0, E_IACK, 4'd3},   // R3 inv during fill
        {S_RSP, K_DAT, 4'd0, E_NONE, 4'd3},
        {S_CPU, K_ST,  4'd0, E_GETM, 4'd3},   // R3 line was left invalid
        {S_RSP, K_ACK, 4'd0, E_NONE, 4'd4},   // R4 early ack
        {S_RSP, K_DAT, 4'd2, E_NONE, 4'd4},
        {S_FWD, K_FRD, 4'd0, E_NONE, 4'd6},
        {S_FWD, K_INV, 4'd0, E_IACK, 4'd7},   // R7
        {S_RSP, K_ACK, 4'd0, E_BOTH, 4'd7},
        {S_CPU, K_LD,  4'd0, E_GETS, 4'd7},   // R7 ended invalid
        {S_RSP, K_DAT, 4'd0, E_NONE, 4'd3},
        {S_CPU, K_ST,  4'd0, E_GETM, 4'd8},   // R8 upgrade
        {S_CPU, K_LD,  4'd0, E_NONE, 4'd9},   // R9 load hits
        {S_RSP, K_DAT, 4'd1, E_NONE, 4'd9},
        {S_FWD, K_FWR, 4'd0, E_NONE, 4'd6},
        {S_RSP, K_ACK, 4'd0, E_REQ,  4'd6},   // R6 fwd write
        {S_CPU, K_ST,  4'd0, E_GETM, 4'd6},
        {S_RSP, K_DAT, 4'd0, E_NONE, 4'd4},   // R4 zero acks
        {S_FWD, K_FRD, 4'd0, E_BOTH, 4'd10},  // R10
        {S_CPU, K_EV,  4'd0, E_PUTS, 4'd8},
        {S_FWD, K_INV, 4'd0, E_IACK, 4'd11},  // R11
        {S_FWD, K_PAK, 4'd0, E_NONE, 4'd11},
        {S_CPU, K_ST,  4'd0, E_GETM, 4'd11},
        {S_RSP, K_DAT, 4'd1, E_NONE, 4'd4},
        {S_RSP, K_ACK, 4'd0, E_NONE, 4'd5},   // R5
        {S_CPU, K_EV,  4'd0, E_PUTM, 4'd5},
        {S_FWD, K_FRD, 4'd0, E_BOTH, 4'd11},
        {S_FWD, K_PAK, 4'd0, E_NONE, 4'd11},
        {S_CPU, K_ST,  4'd0, E_GETM, 4'd11},
        {S_RSP, K_DAT, 4'd0, E_NONE, 4'd4},
        {S_CPU, K_EV,  4'd0, E_PUTM, 4'd10},
        {S_FWD, K_FWR, 4'd0, E_REQ,  4'd11},
        {S_FWD, K_PAK, 4'd0, E_NONE, 4'd11},
        {S_CPU, K_LD,  4'd0, E_GETS, 4'd11},
        {S_RSP, K_DAT, 4'd0, E_NONE, 4'd3},
        {S_CPU, K_ST,  4'd0, E_GETM, 4'd8},
        {S_FWD, K_INV, 4'd0, E_IACK, 4'd9},   // R9 inv during upgrade
        {S_RSP, K_DAT, 4'd1, E_NONE, 4'd9},
        {S_FWD, K_FRD, 4'd0, E_NONE, 4'd6},
        {S_RSP, K_ACK, 4'd0, E_BOTH, 4'd6},   // R6 fwd read
        {S_CPU, K_EV,  4'd0, E_PUTS, 4'd6},   // ended shared
        {S_FWD, K_PAK, 4'd0, E_NONE, 4'd11},
        {S_CPU, K_ST,  4'd0, E_GETM, 4'd11},
        {S_RSP, K_DAT, 4'd2, E_NONE, 4'd4},
        {S_RSP, K_ACK, 4'd0, E_NONE, 4'd5},
        {S_FWD, K_FWR, 4'd0, E_NONE, 4'd6},
        {S_RSP, K_ACK, 4'd0, E_REQ,  4'd5},
        {S_CPU, K_LD,  4'd0, E_GETS, 4'd6},
        {S_RSP, K_DAT, 4'd0, E_NONE, 4'd3},
        {S_CPU, K_ST,  4'd0, E_GETM, 4'd8},
        {S_RSP, K_DAT, 4'd1, E_NONE, 4'd9},
        {S_FWD, K_FRD, 4'd0, E_NONE, 4'd6},
        {S_FWD, K_INV, 4'd0, E_IACK, 4'd7},
        {S_RSP, K_ACK, 4'd0, E_BOTH, 4'd7},
        {S_CPU, K_LD,  4'd0, E_GETS, 4'd7},
        {S_RSP, K_DAT, 4'd0, E_NONE, 4'd3},
        {S_CPU, K_ST,  4'd0, E_GETM, 4'd8},
        {S_RSP, K_DAT, 4'd0, E_NONE, 4'd9},
        {S_FWD, K_FWR, 4'd0, E_REQ,  4'd10},
        {S_CPU, K_ST,  4'd0, E_GETM, 4'd10}
    };

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int outs();
        return int'({req_valid, req_kind, data_to_req, data_to_dir, inv_ack_out});
    endfunction

    task automatic idle();
        cpu_valid = 1'b0; fwd_valid = 1'b0; rsp_valid = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    task automatic run_vec(logic [17:0] v);
        case (v[17:16])
            S_CPU:   begin cpu_valid = 1'b1; cpu_op = v[15:14]; end
            S_FWD:   begin fwd_valid = 1'b1; fwd_kind = v[15:14]; end
            S_RSP:   begin rsp_valid = 1'b1; rsp_kind = v[14]; rsp_acks = v[12:10]; end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        idle();
        chk($sformatf("R%0d event outputs", v[3:0]), outs(), int'(v[9:4]));
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        idle();
        cpu_op = 2'd0; fwd_kind = 2'd0; rsp_kind = 1'b0; rsp_acks = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 outputs after reset", outs(), 0);
        chk("R1 fwd_ready after reset", int'(fwd_ready), 1);
        cpu_valid = 1'b1; cpu_op = K_LD; #1;
        chk("R1 load not stalled", int'(cpu_stall), 0);
        cpu_valid = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R13 forwarded read held during a write fill
        fwd_valid = 1'b1; fwd_kind = K_FRD; #1;
        chk("R13 fwd held in fill", int'(fwd_ready), 0);
        @(posedge clk); @(negedge clk);
        chk("R13 no output while held", outs(), 0);
        chk("R13 still held", int'(fwd_ready), 0);
        rsp_valid = 1'b1; rsp_kind = K_DAT[0]; rsp_acks = '0;
        @(posedge clk); @(negedge clk);
        rsp_valid = 1'b0;
        chk("R13 data taken first", outs(), 0);
        #1 chk("R13 fwd ready after data", int'(fwd_ready), 1);
        @(posedge clk); @(negedge clk);
        fwd_valid = 1'b0;
        chk("R13 deferred read served", outs(), int'(E_BOTH));

        // R12 stall rules (line now shared)
        cpu_valid = 1'b1; cpu_op = K_LD; fwd_valid = 1'b1; fwd_kind = K_INV; #1;
        chk("R12 load stalls beside message", int'(cpu_stall), 1);
        fwd_valid = 1'b0; #1;
        chk("R12 shared load hits", int'(cpu_stall), 0);
        cpu_valid = 1'b0;
        run_vec({S_CPU, K_ST, 4'd0, E_GETM, 4'd12});
        cpu_valid = 1'b1; cpu_op = K_ST; #1;
        chk("R12 store stalls in upgrade", int'(cpu_stall), 1);
        cpu_op = K_LD; #1;
        chk("R12 load hits in upgrade", int'(cpu_stall), 0);
        cpu_op = K_EV; #1;
        chk("R12 evict stalls in upgrade", int'(cpu_stall), 1);
        cpu_valid = 1'b0;
        run_vec({S_RSP, K_DAT, 4'd0, E_NONE, 4'd12});
        run_vec({S_CPU, K_EV, 4'd0, E_PUTM, 4'd12});
        cpu_valid = 1'b1; cpu_op = K_LD; #1;
        chk("R12 load stalls while put pending", int'(cpu_stall), 1);
        cpu_valid = 1'b0;
        run_vec({S_FWD, K_PAK, 4'd0, E_NONE, 4'd12});

        // R1 reset in the middle of an ack gather
        run_vec({S_CPU, K_ST, 4'd0, E_GETM, 4'd1});
        run_vec({S_RSP, K_DAT, 4'd2, E_NONE, 4'd1});
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 outputs after mid reset", outs(), 0);
        cpu_valid = 1'b1; cpu_op = K_EV; #1;
        chk("R1 evict not stalled after reset", int'(cpu_stall), 0);
        cpu_valid = 1'b0;
        run_vec({S_CPU, K_EV, 4'd0, E_NONE, 4'd1});
        run_vec({S_CPU, K_ST, 4'd0, E_GETM, 4'd1});

        done = 1'b1;
        report();
        $finish;
    end
endmodule